// File: doc/BRIEF.md
# Processor-to-External-Bus Queueing Front End

This block sits between a processor register port and an external-bus engine. It keeps the processor clear of external bus timing. A processor write lands in a small write queue and returns at once. The queue then drains to the bus engine in order. Reads come in two kinds. A blocking read holds the processor's request until the data comes back. A streaming (non-blocking) read is started by giving a start address and a word count. The block then issues one bus read per word, with the address stepping by four bytes, and stacks the returned words in a read queue. The processor or a DMA engine empties that queue later.

The bus engine is seen as a command port with valid/ready handshake and a response strobe. Only one command is in flight at any time. Queued writes go out first. A blocking read comes next, and only once the write queue is empty. Streaming reads come last, and only while the read queue has room. Two DMA request lines are derived from the queue levels. The write request is high whenever the write queue is empty. The read request compares the read-queue level against a programmable watermark.

Top module: `busq_front`

## Requirements
- R1: A processor write is accepted (cpu_wr_ready high) whenever the write queue holds fewer than 4 entries, whatever the state of the bus. With 4 entries held, cpu_wr_ready is low and a write offered then is dropped.
- R2: Queued writes reach the bus in arrival order, each as one command with bus_cmd_write=1 and the address and data given by the processor.
- R3: A blocking read is not presented to the bus while the write queue holds any entry. cpu_brd_done pulses in the same cycle as the bus response that answers it, with cpu_brd_data equal to bus_rsp_data.
- R4: After nb_start with address A and count N, the block issues N read commands at A, A+4, A+8 and so on. The returned words leave through rf_data/rf_pop in the same order.
- R5: Streaming reads pause while the read queue holds 8 words, and resume after a pop.
- R6: dma_wr_req is high exactly when the write queue is empty.
- R7: With watermark T in 1..8, dma_rd_req is high when rf_count >= T. With T = 0, dma_rd_req stays low.
- R8: A watermark write (cfg_thr_we) with a value above 8 is ignored, and the previous watermark stays in force.
- R9: wf_full and wf_empty report the write-queue state, and rf_count gives the number of words in the read queue (0..8).
- R10: At most one read is outstanding: no command is offered while a response is awaited. A bus response with no read outstanding changes neither the read queue nor cpu_brd_done.
- R11: After reset, both queues are empty, no command is offered, dma_wr_req=1, dma_rd_req=0 and the watermark is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_valid | input | 1 | Processor write strobe |
| cpu_wr_addr | input | ADDR_W | Write address |
| cpu_wr_data | input | DATA_W | Write data |
| cpu_wr_ready | output | 1 | Write queue has room |
| cpu_brd_req | input | 1 | Blocking read request, held until done |
| cpu_brd_addr | input | ADDR_W | Blocking read address |
| cpu_brd_done | output | 1 | Blocking read data valid (one cycle) |
| cpu_brd_data | output | DATA_W | Blocking read data |
| nb_start | input | 1 | Start a streaming read sequence |
| nb_addr | input | ADDR_W | Streaming start address |
| nb_count | input | CNT_W | Number of words to fetch |
| cfg_thr_we | input | 1 | Watermark write strobe |
| cfg_thr_val | input | clog2(RF_DEPTH+1) | Watermark value |
| rf_pop | input | 1 | Pop the read queue head |
| rf_data | output | DATA_W | Read queue head |
| rf_count | output | clog2(RF_DEPTH+1) | Read queue level |
| wf_full | output | 1 | Write queue full |
| wf_empty | output | 1 | Write queue empty |
| dma_rd_req | output | 1 | Read-direction DMA request |
| dma_wr_req | output | 1 | Write-direction DMA request |
| bus_cmd_valid | output | 1 | Command offered to bus engine |
| bus_cmd_ready | input | 1 | Bus engine accepts command |
| bus_cmd_write | output | 1 | 1 = write command, 0 = read |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_wdata | output | DATA_W | Write data for write commands |
| bus_rsp_valid | input | 1 | Read response strobe |
| bus_rsp_data | input | DATA_W | Read response data |

## Verification
Writes are first offered while the bus is held off. This separates acceptance into the queue from bus progress, and a fifth write against a full queue shows whether the drop is honoured. A blocking read is posted behind pending writes and the bus is then released. The command order shows whether the read overtakes the writes. Streaming reads run against a ready line that toggles every cycle. A 5-word run steps the level across the watermark from both sides. A 12-word run hits the 8-word ceiling, which shows whether issue stops there and starts again after a pop. A stray response injected while idle shows whether unsolicited data can leak into the queue.

// File: rtl/busq_pkg.sv
package busq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_WAIT_BLK = 2'd1,
        SQ_WAIT_NB  = 2'd2
    } sq_state_e;

    parameter int unsigned BQ_ADDR_STEP = 4;
endpackage

// File: rtl/busq_fifo.sv
module busq_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign count   = st_q.cnt;
    assign dout    = mem_q[st_q.rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(DEPTH-1)) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH-1)) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= din;
    end

    AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R9
    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full); // R9
endmodule

// File: rtl/busq_seq.sv
module busq_seq
    import busq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wf_empty,
    input  logic [ADDR_W-1:0] wf_addr,
    input  logic [DATA_W-1:0] wf_data,
    output logic              wf_pop,
    input  logic              brd_req,
    input  logic [ADDR_W-1:0] brd_addr,
    output logic              brd_done,
    input  logic              nb_start,
    input  logic [ADDR_W-1:0] nb_addr,
    input  logic [CNT_W-1:0]  nb_count,
    input  logic              rf_full,
    output logic              rf_push,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid
);
    typedef struct packed {
        sq_state_e         state;
        logic [ADDR_W-1:0] nb_addr;
        logic [CNT_W-1:0]  nb_left;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic idle, pick_wr, pick_brd, pick_nb, fire;

    always_comb begin
        idle      = (st_q.state == SQ_IDLE);
        pick_wr   = idle && !wf_empty;
        pick_brd  = idle && wf_empty && brd_req;
        pick_nb   = idle && wf_empty && !brd_req && (st_q.nb_left != '0) && !rf_full;
        cmd_valid = pick_wr || pick_brd || pick_nb;
        cmd_write = pick_wr;
        cmd_addr  = pick_wr ? wf_addr : (pick_brd ? brd_addr : st_q.nb_addr);
        cmd_wdata = wf_data;
        fire      = cmd_valid && cmd_ready;
        wf_pop    = fire && pick_wr;
        brd_done  = (st_q.state == SQ_WAIT_BLK) && rsp_valid;
        rf_push   = (st_q.state == SQ_WAIT_NB) && rsp_valid;

        st_d = st_q;
        case (st_q.state)
            SQ_IDLE: begin
                if (fire && pick_brd) begin
                    st_d.state = SQ_WAIT_BLK;
                end else if (fire && pick_nb) begin
                    st_d.state   = SQ_WAIT_NB;
                    st_d.nb_addr = st_q.nb_addr + ADDR_W'(BQ_ADDR_STEP);
                    st_d.nb_left = st_q.nb_left - 1'b1;
                end
            end
            SQ_WAIT_BLK, SQ_WAIT_NB: begin
                if (rsp_valid) st_d.state = SQ_IDLE;
            end
            default: st_d.state = SQ_IDLE;
        endcase
        if (nb_start) begin
            st_d.nb_addr = nb_addr;
            st_d.nb_left = nb_count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: SQ_IDLE, nb_addr: '0, nb_left: '0};
        else        st_q <= st_d;
    end

    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |-> wf_empty); // R3
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_write |=> !cmd_valid); // R10
    AST_NO_RF_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rf_push |-> !rf_full); // R5
endmodule

// File: rtl/busq_front.sv
module busq_front
    import busq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WF_DEPTH = 4,
    parameter int unsigned RF_DEPTH = 8,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cpu_wr_valid,
    input  logic [ADDR_W-1:0]               cpu_wr_addr,
    input  logic [DATA_W-1:0]               cpu_wr_data,
    output logic                            cpu_wr_ready,
    input  logic                            cpu_brd_req,
    input  logic [ADDR_W-1:0]               cpu_brd_addr,
    output logic                            cpu_brd_done,
    output logic [DATA_W-1:0]               cpu_brd_data,
    input  logic                            nb_start,
    input  logic [ADDR_W-1:0]               nb_addr,
    input  logic [CNT_W-1:0]                nb_count,
    input  logic                            cfg_thr_we,
    input  logic [$clog2(RF_DEPTH+1)-1:0]   cfg_thr_val,
    input  logic                            rf_pop,
    output logic [DATA_W-1:0]               rf_data,
    output logic [$clog2(RF_DEPTH+1)-1:0]   rf_count,
    output logic                            wf_full,
    output logic                            wf_empty,
    output logic                            dma_rd_req,
    output logic                            dma_wr_req,
    output logic                            bus_cmd_valid,
    input  logic                            bus_cmd_ready,
    output logic                            bus_cmd_write,
    output logic [ADDR_W-1:0]               bus_cmd_addr,
    output logic [DATA_W-1:0]               bus_cmd_wdata,
    input  logic                            bus_rsp_valid,
    input  logic [DATA_W-1:0]               bus_rsp_data
);
    localparam int unsigned RC_W  = $clog2(RF_DEPTH+1);
    localparam int unsigned WC_W  = $clog2(WF_DEPTH+1);
    localparam int unsigned WE_W  = ADDR_W + DATA_W;

    typedef struct packed {
        logic [RC_W-1:0] thr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WE_W-1:0] wf_head;
    logic [WC_W-1:0] wf_count;
    logic            wf_pop, rf_push, rf_full, rf_empty;

    busq_fifo #(.WIDTH(WE_W), .DEPTH(WF_DEPTH)) u_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cpu_wr_valid),
        .din   ({cpu_wr_addr, cpu_wr_data}),
        .pop   (wf_pop),
        .dout  (wf_head),
        .full  (wf_full),
        .empty (wf_empty),
        .count (wf_count)
    );

    busq_fifo #(.WIDTH(DATA_W), .DEPTH(RF_DEPTH)) u_rfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rf_push),
        .din   (bus_rsp_data),
        .pop   (rf_pop),
        .dout  (rf_data),
        .full  (rf_full),
        .empty (rf_empty),
        .count (rf_count)
    );

    busq_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wf_empty  (wf_empty),
        .wf_addr   (wf_head[WE_W-1:DATA_W]),
        .wf_data   (wf_head[DATA_W-1:0]),
        .wf_pop    (wf_pop),
        .brd_req   (cpu_brd_req),
        .brd_addr  (cpu_brd_addr),
        .brd_done  (cpu_brd_done),
        .nb_start  (nb_start),
        .nb_addr   (nb_addr),
        .nb_count  (nb_count),
        .rf_full   (rf_full),
        .rf_push   (rf_push),
        .cmd_valid (bus_cmd_valid),
        .cmd_ready (bus_cmd_ready),
        .cmd_write (bus_cmd_write),
        .cmd_addr  (bus_cmd_addr),
        .cmd_wdata (bus_cmd_wdata),
        .rsp_valid (bus_rsp_valid)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_thr_we && (cfg_thr_val <= RC_W'(RF_DEPTH))) begin
            st_d.thr = cfg_thr_val;
        end
        cpu_wr_ready = !wf_full;
        cpu_brd_data = bus_rsp_data;
        dma_wr_req   = wf_empty;
        dma_rd_req   = (st_q.thr != '0) && (rf_count >= st_q.thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.thr <= RC_W'(RF_DEPTH)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && (wf_count < WC_W'(WF_DEPTH)) |=> (wf_count != '0)); // R1
    AST_RSP_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rf_push |-> !rf_full || rf_empty); // R5
endmodule

// File: tb/sim_busq_front.sv
module sim_busq_front;
    localparam int AW = 32, DW = 32, CW = 16, TW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          cpu_wr_valid, cpu_wr_ready;
    logic [AW-1:0] cpu_wr_addr;
    logic [DW-1:0] cpu_wr_data;
    logic          cpu_brd_req, cpu_brd_done;
    logic [AW-1:0] cpu_brd_addr;
    logic [DW-1:0] cpu_brd_data;
    logic          nb_start;
    logic [AW-1:0] nb_addr;
    logic [CW-1:0] nb_count;
    logic          cfg_thr_we;
    logic [TW-1:0] cfg_thr_val;
    logic          rf_pop;
    logic [DW-1:0] rf_data;
    logic [TW-1:0] rf_count;
    logic          wf_full, wf_empty, dma_rd_req, dma_wr_req;
    logic          bus_cmd_valid, bus_cmd_ready, bus_cmd_write;
    logic [AW-1:0] bus_cmd_addr;
    logic [DW-1:0] bus_cmd_wdata;
    logic          bus_rsp_valid;
    logic [DW-1:0] bus_rsp_data;

    busq_front u0 (.*);

    typedef struct {
        bit          wr;
        logic [31:0] a;
        logic [31:0] d;
    } cmd_t;

    cmd_t        exp_q[$];
    logic [31:0] rf_exp_q[$];
    int n_chk = 0, n_fail = 0, rd_seen = 0;
    bit bus_hold = 1'b1, slow = 1'b0, tog = 1'b0, inject = 1'b0, pend = 1'b0;
    int lat = 0;
    logic [31:0] paddr;

    function automatic logic [31:0] rsp_of(logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus engine model and command scoreboard monitor
    initial begin
        bus_cmd_ready = 1'b0; bus_rsp_valid = 1'b0; bus_rsp_data = '0;
        forever begin
            @(posedge clk); #1;
            bus_rsp_valid = 1'b0;
            if (inject) begin
                bus_rsp_valid = 1'b1; bus_rsp_data = 32'hDEAD_BEEF;
            end else if (pend) begin
                if (lat == 0) begin
                    bus_rsp_valid = 1'b1; bus_rsp_data = rsp_of(paddr); pend = 1'b0;
                end else lat--;
            end
            tog = ~tog;
            bus_cmd_ready = !bus_hold && !(slow && tog);
            @(negedge clk);
            if (rst_n && bus_cmd_valid && bus_cmd_ready) begin
                if (exp_q.size() == 0) begin
                    chk_eq("R2 unexpected bus command", bus_cmd_addr, 32'hFFFF_FFFF);
                end else begin
                    cmd_t e;
                    e = exp_q.pop_front();
                    chk_eq(e.wr ? "R2 write order/addr" : "R4 read order/addr",
                           {bus_cmd_write, bus_cmd_addr[30:0]}, {e.wr, e.a[30:0]});
                    if (e.wr) chk_eq("R2 write data", bus_cmd_wdata, e.d);
                end
                if (!bus_cmd_write) begin
                    pend = 1'b1; lat = 1; paddr = bus_cmd_addr; rd_seen++;
                end
            end
        end
    end

    task automatic do_write(logic [31:0] a, logic [31:0] d, bit expect_ok);
        @(posedge clk); #1;
        cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
        @(negedge clk);
        chk_eq("R1 write acceptance", 32'(cpu_wr_ready), 32'(expect_ok));
        if (expect_ok) exp_q.push_back('{1'b1, a, d});
        @(posedge clk); #1;
        cpu_wr_valid = 1'b0;
    endtask

    task automatic set_thr(logic [TW-1:0] v);
        @(posedge clk); #1;
        cfg_thr_we = 1'b1; cfg_thr_val = v;
        @(posedge clk); #1;
        cfg_thr_we = 1'b0;
    endtask

    task automatic start_nb(logic [31:0] a, int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{1'b0, a + 32'(4*i), 32'h0});
            rf_exp_q.push_back(rsp_of(a + 32'(4*i)));
        end
        @(posedge clk); #1;
        nb_start = 1'b1; nb_addr = a; nb_count = CW'(n);
        @(posedge clk); #1;
        nb_start = 1'b0;
    endtask

    task automatic pop_one();
        while (rf_count == 0) @(negedge clk);
        @(posedge clk); #1;
        rf_pop = 1'b1;
        @(negedge clk);
        chk_eq("R4 read queue data", rf_data, rf_exp_q.pop_front());
        @(posedge clk); #1;
        rf_pop = 1'b0;
    endtask

    task automatic wait_level(int n);
        while (32'(rf_count) != n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cpu_wr_valid = 0; cpu_wr_addr = '0; cpu_wr_data = '0;
        cpu_brd_req = 0; cpu_brd_addr = '0; nb_start = 0; nb_addr = '0; nb_count = '0;
        cfg_thr_we = 0; cfg_thr_val = '0; rf_pop = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_eq("R11 wf_empty", 32'(wf_empty), 1);
        chk_eq("R11 wf_full", 32'(wf_full), 0);
        chk_eq("R11 rf_count", 32'(rf_count), 0);
        chk_eq("R11 dma_wr_req", 32'(dma_wr_req), 1);
        chk_eq("R11 dma_rd_req", 32'(dma_rd_req), 0);
        chk_eq("R11 no command", 32'(bus_cmd_valid), 0);

        // R1/R2/R6/R9: fill write queue with bus stalled, fifth write dropped
        for (int i = 0; i < 4; i++) do_write(32'h1000 + 32'(4*i), 32'hA000_0000 + 32'(i), 1'b1);
        do_write(32'h1FFC, 32'hBAD0_0000, 1'b0);
        @(negedge clk);
        chk_eq("R9 wf_full", 32'(wf_full), 1);
        chk_eq("R6 dma_wr_req with entries", 32'(dma_wr_req), 0);
        bus_hold = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk_eq("R9 wf_empty after drain", 32'(wf_empty), 1);
        chk_eq("R6 dma_wr_req when empty", 32'(dma_wr_req), 1);

        // R3: blocking read posted behind two writes
        bus_hold = 1'b1;
        do_write(32'h2000, 32'h1111_2222, 1'b1);
        do_write(32'h2004, 32'h3333_4444, 1'b1);
        @(posedge clk); #1;
        cpu_brd_req = 1'b1; cpu_brd_addr = 32'h0000_2ABC;
        exp_q.push_back('{1'b0, 32'h0000_2ABC, 32'h0});
        bus_hold = 1'b0;
        @(negedge clk);
        while (!cpu_brd_done) @(negedge clk);
        chk_eq("R3 blocking read data", cpu_brd_data, rsp_of(32'h0000_2ABC));
        chk_eq("R3 writes issued before read", 32'(exp_q.size()), 0);
        @(posedge clk); #1;
        cpu_brd_req = 1'b0;

        // R4/R7: streaming read of 5 with watermark 3, ready toggling
        slow = 1'b1;
        set_thr(4'd3);
        start_nb(32'h0000_0100, 5);
        wait_level(5);
        @(negedge clk);
        chk_eq("R9 rf_count after 5", 32'(rf_count), 5);
        chk_eq("R7 dma_rd_req at 5>=3", 32'(dma_rd_req), 1);
        pop_one(); pop_one();
        @(negedge clk);
        chk_eq("R7 dma_rd_req at 3>=3", 32'(dma_rd_req), 1);
        pop_one();
        @(negedge clk);
        chk_eq("R7 dma_rd_req at 2<3", 32'(dma_rd_req), 0);
        pop_one(); pop_one();

        // R5/R7: 12-word run pauses at 8
        set_thr(4'd8);
        rd_seen = 0;
        start_nb(32'h0000_0200, 12);
        wait_level(8);
        repeat (20) @(negedge clk);
        chk_eq("R5 level holds at 8", 32'(rf_count), 8);
        chk_eq("R5 reads paused at 8", 32'(rd_seen), 8);
        chk_eq("R7 dma_rd_req at 8>=8", 32'(dma_rd_req), 1);
        pop_one();
        @(negedge clk);
        chk_eq("R7 dma_rd_req at 7<8", 32'(dma_rd_req), 0);
        for (int i = 0; i < 11; i++) pop_one();
        repeat (4) @(negedge clk);
        chk_eq("R5 resumed to full count", 32'(rd_seen), 12);

        // R7/R8: watermark 0 disables, out-of-range ignored
        set_thr(4'd0);
        start_nb(32'h0000_0300, 2);
        wait_level(2);
        @(negedge clk);
        chk_eq("R7 watermark 0 keeps request low", 32'(dma_rd_req), 0);
        set_thr(4'd2);
        @(negedge clk);
        chk_eq("R7 watermark 2 at level 2", 32'(dma_rd_req), 1);
        set_thr(4'd9);
        @(negedge clk);
        chk_eq("R8 watermark 9 ignored", 32'(dma_rd_req), 1);

        // R10: stray response while idle
        repeat (4) @(negedge clk);
        inject = 1'b1;
        @(negedge clk);
        chk_eq("R10 stray rsp no done", 32'(cpu_brd_done), 0);
        inject = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R10 stray rsp not queued", 32'(rf_count), 2);
        pop_one(); pop_one();
        repeat (3) @(negedge clk);
        chk_eq("R4 all commands seen", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule